// File: doc/BRIEF.md
# Self-Expiring Cache Tag Store with Adaptive Decay

This block holds the tags of a small set-associative cache. Every line has a valid bit, a tag and a time-to-live counter. A line gets a pseudo-random lifetime when it is filled, and a fresh one each time it hits. A shared decay tick lowers the lifetime of every live line. A line that runs out drops out of the cache by itself and is reported on a one-cycle expiry mask.

The interval between decay ticks is not fixed. It follows an additive-increase / multiplicative-decrease rule. When a refill has to replace a line that is still live, the interval is halved, so lines age faster and free ways sooner. When a full window of lookups passes without such a replacement, the interval grows by a fixed step. The surrounding cache controller sends lookups and, after a miss, sends the refill. The block picks the victim way and reports it.

Top module: `ttl_tag_cache`

## Requirements
- R1: A lookup (`lk_valid`=1, `fill_valid`=0) gives a response on the next cycle: `rsp_valid`=1, and `rsp_hit`=1 exactly when a valid line of `lk_set` holds `lk_tag`, with `rsp_way` naming the lowest such way.
- R2: A 16-bit shift register starts at 0xACE1 after reset. Each step it shifts left and brings in bit15^bit13^bit12^bit10 at bit 0. Each lifetime load uses TTL_MIN + (register & (TTL_MAX-TTL_MIN)), and the span must be a power of two. The register then steps once. A refill loads the victim line with this value.
- R3: A lookup hit reloads the hit line's lifetime from the same generator, which also steps.
- R4: The decay tick occurs once every `decay_period` cycles, the first one `decay_period` cycles after reset. It lowers the lifetime of every valid line by one.
- R5: A line whose lifetime is 1 when a tick applies becomes invalid. One cycle later, bit set*WAYS+way of `exp_mask` is 1 for exactly one cycle.
- R6: When a tick and a hit-refresh or refill fall in the same cycle on the same line, the line takes the new lifetime. It is neither decremented nor expired.
- R7: A refill answers on the next cycle with `fill_done`=1 and `fill_way` equal to the victim. The victim is the lowest invalid way of `fill_set`. If every way is valid, it is the way with the smallest lifetime (lowest index on a tie), and `fill_conflict`=1.
- R8: A conflict refill sets `decay_period` to half its value, rounded down and no lower than PER_MIN, and restarts the lookup window.
- R9: Every WIN lookups with no conflict refill between them raise `decay_period` by PER_STEP, capped at PER_MAX.
- R10: When a refill and a lookup arrive in the same cycle, the refill is served and the lookup is dropped, with no response and no window count.
- R11: After reset, all lines are invalid, `decay_period` is PER_INIT, and `rsp_valid`, `fill_done` and `exp_mask` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_set | input | SET_W | Lookup set index |
| lk_tag | input | TAG_W | Lookup tag |
| rsp_valid | output | 1 | Lookup response strobe |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | WAY_W | Way that hit |
| fill_valid | input | 1 | Refill request |
| fill_set | input | SET_W | Refill set index |
| fill_tag | input | TAG_W | Tag to install |
| fill_done | output | 1 | Refill complete strobe |
| fill_way | output | WAY_W | Way that was written |
| fill_conflict | output | 1 | Refill replaced a live line |
| exp_mask | output | SETS*WAYS | One-cycle lifetime-expiry flags, one per line |
| decay_period | output | PER_W | Current decay tick interval in cycles |

## Verification
Lookup responses, refill results, expiry flags and the new decay interval all come from one register stage. Each is therefore due on the cycle after the edge that took the request or applied the tick. The bench drives inputs just after a rising edge. Before that edge it advances its reference model by one cycle, and one time unit after the edge it compares every output with the model. No output is sampled at an edge. Directed phases time lookups and refills so that they land exactly on decay ticks and on window boundaries.

// File: rtl/ttl_pkg.sv
package ttl_pkg;
  localparam logic [15:0] RNG_SEED = 16'hACE1;

  function automatic logic [15:0] rng_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/ttl_rng.sv
module ttl_rng #(
  parameter int TTL_W   = 4,
  parameter int TTL_MIN = 4,
  parameter int TTL_MAX = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [TTL_W-1:0] value
);
  localparam int SPAN   = TTL_MAX - TTL_MIN + 1;
  localparam int SPAN_W = (SPAN > 1) ? $clog2(SPAN) : 1;

  logic [15:0] state_q;

  assign value = TTL_W'(TTL_MIN) + TTL_W'(state_q[SPAN_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst)      state_q <= ttl_pkg::RNG_SEED;
    else if (adv) state_q <= ttl_pkg::rng_next(state_q);
  end
endmodule

// File: rtl/ttl_decay_ctrl.sv
module ttl_decay_ctrl #(
  parameter int PER_W    = 8,
  parameter int PER_INIT = 16,
  parameter int PER_MIN  = 2,
  parameter int PER_MAX  = 64,
  parameter int PER_STEP = 4,
  parameter int WIN      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lookup_ev,
  input  logic             conflict_ev,
  output logic             tick,
  output logic [PER_W-1:0] period
);
  localparam int WIN_W = (WIN > 1) ? $clog2(WIN) : 1;

  logic [PER_W-1:0] cnt_q, period_q, halved, grown;
  logic [PER_W:0]   sum;
  logic [WIN_W-1:0] win_q;

  assign tick   = (cnt_q >= period_q - PER_W'(1));
  assign period = period_q;

  always_comb begin
    halved = period_q >> 1;
    if (halved < PER_W'(PER_MIN)) halved = PER_W'(PER_MIN);
    sum   = {1'b0, period_q} + (PER_W+1)'(PER_STEP);
    grown = (sum > (PER_W+1)'(PER_MAX)) ? PER_W'(PER_MAX) : sum[PER_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      period_q <= PER_W'(PER_INIT);
      win_q    <= '0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + PER_W'(1);
      if (conflict_ev) begin
        period_q <= halved;
        win_q    <= '0;
      end else if (lookup_ev) begin
        if (win_q == WIN_W'(WIN - 1)) begin
          win_q    <= '0;
          period_q <= grown;
        end else begin
          win_q <= win_q + WIN_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ttl_line_store.sv
module ttl_line_store #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  parameter int TTL_W = 4,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int NL    = SETS * WAYS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             look_go,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             fill_go,
  input  logic [SET_W-1:0] fill_set,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             tick,
  input  logic [TTL_W-1:0] rnd,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  output logic [WAY_W-1:0] victim,
  output logic             all_live,
  output logic [NL-1:0]    exp_now
);
  logic [NL-1:0]            valid_q;
  logic [NL-1:0][TTL_W-1:0] ttl_q;
  logic [NL-1:0][TAG_W-1:0] tag_q;
  logic [NL-1:0]            fill_sel, hit_sel;
  logic [TTL_W-1:0]         best;

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (valid_q[int'(lk_set) * WAYS + w] && tag_q[int'(lk_set) * WAYS + w] == lk_tag) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end

  always_comb begin
    all_live = 1'b1;
    victim   = '0;
    best     = ttl_q[int'(fill_set) * WAYS];
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_q[int'(fill_set) * WAYS + w]) begin
        all_live = 1'b0;
        victim   = WAY_W'(w);
      end
    end
    if (all_live) begin
      for (int w = 1; w < WAYS; w++) begin
        if (ttl_q[int'(fill_set) * WAYS + w] < best) begin
          best   = ttl_q[int'(fill_set) * WAYS + w];
          victim = WAY_W'(w);
        end
      end
    end
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      localparam int L = s * WAYS + w;
      assign fill_sel[L] = fill_go && fill_set == SET_W'(s) && victim == WAY_W'(w);
      assign hit_sel[L]  = look_go && hit && lk_set == SET_W'(s) && hit_way == WAY_W'(w);
      assign exp_now[L]  = !fill_sel[L] && !hit_sel[L] && tick && valid_q[L]
                           && ttl_q[L] == TTL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NL; i++) begin
      if (fill_sel[i]) tag_q[i] <= fill_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      ttl_q   <= '0;
    end else begin
      for (int i = 0; i < NL; i++) begin
        if (fill_sel[i]) begin
          valid_q[i] <= 1'b1;
          ttl_q[i]   <= rnd;
        end else if (hit_sel[i]) begin
          ttl_q[i] <= rnd;
        end else if (tick && valid_q[i]) begin
          if (ttl_q[i] == TTL_W'(1)) valid_q[i] <= 1'b0;
          ttl_q[i] <= ttl_q[i] - TTL_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ttl_tag_cache.sv
module ttl_tag_cache #(
  parameter int SETS     = 4,
  parameter int WAYS     = 4,
  parameter int TAG_W    = 8,
  parameter int TTL_W    = 4,
  parameter int TTL_MIN  = 4,
  parameter int TTL_MAX  = 11,
  parameter int PER_W    = 8,
  parameter int PER_INIT = 16,
  parameter int PER_MIN  = 2,
  parameter int PER_MAX  = 64,
  parameter int PER_STEP = 4,
  parameter int WIN      = 8,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int NL    = SETS * WAYS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [WAY_W-1:0] rsp_way,
  input  logic             fill_valid,
  input  logic [SET_W-1:0] fill_set,
  input  logic [TAG_W-1:0] fill_tag,
  output logic             fill_done,
  output logic [WAY_W-1:0] fill_way,
  output logic             fill_conflict,
  output logic [NL-1:0]    exp_mask,
  output logic [PER_W-1:0] decay_period
);
  logic             look_go, tick, hit, all_live, conflict_ev;
  logic [WAY_W-1:0] hit_way, victim;
  logic [TTL_W-1:0] rnd;
  logic [NL-1:0]    exp_now;

  assign look_go     = lk_valid && !fill_valid;
  assign conflict_ev = fill_valid && all_live;

  ttl_rng #(.TTL_W(TTL_W), .TTL_MIN(TTL_MIN), .TTL_MAX(TTL_MAX)) u_rng (
    .clk(clk), .rst(rst), .adv(fill_valid || (look_go && hit)), .value(rnd)
  );

  ttl_decay_ctrl #(
    .PER_W(PER_W), .PER_INIT(PER_INIT), .PER_MIN(PER_MIN),
    .PER_MAX(PER_MAX), .PER_STEP(PER_STEP), .WIN(WIN)
  ) u_decay (
    .clk(clk), .rst(rst), .lookup_ev(look_go), .conflict_ev(conflict_ev),
    .tick(tick), .period(decay_period)
  );

  ttl_line_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .TTL_W(TTL_W)) u_store (
    .clk(clk), .rst(rst), .look_go(look_go), .lk_set(lk_set), .lk_tag(lk_tag),
    .fill_go(fill_valid), .fill_set(fill_set), .fill_tag(fill_tag),
    .tick(tick), .rnd(rnd), .hit(hit), .hit_way(hit_way), .victim(victim),
    .all_live(all_live), .exp_now(exp_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_way       <= '0;
      fill_done     <= 1'b0;
      fill_way      <= '0;
      fill_conflict <= 1'b0;
      exp_mask      <= '0;
    end else begin
      rsp_valid     <= look_go;
      rsp_hit       <= look_go && hit;
      rsp_way       <= (look_go && hit) ? hit_way : '0;
      fill_done     <= fill_valid;
      fill_way      <= fill_valid ? victim : '0;
      fill_conflict <= conflict_ev;
      exp_mask      <= exp_now;
    end
  end
endmodule

// File: rtl/ttl_tag_cache_chk.sv
module ttl_tag_cache_chk #(
  parameter int NL      = 16,
  parameter int PER_W   = 8,
  parameter int PER_MIN = 2,
  parameter int PER_MAX = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_valid,
  input logic             fill_valid,
  input logic             rsp_valid,
  input logic             fill_done,
  input logic             fill_conflict,
  input logic [NL-1:0]    exp_mask,
  input logic [PER_W-1:0] decay_period
);
  p_rsp_next_r1: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !fill_valid) |=> rsp_valid);

  p_drop_lookup_r10: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> !rsp_valid);

  p_fill_done_r7: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> fill_done);

  p_period_bounds_r9: assert property (@(posedge clk) disable iff (rst)
    decay_period >= PER_W'(PER_MIN) && decay_period <= PER_W'(PER_MAX));

  p_halve_r8: assert property (@(posedge clk) disable iff (rst)
    (fill_done && fill_conflict) |->
      decay_period == ((($past(decay_period) >> 1) < PER_W'(PER_MIN)) ?
                       PER_W'(PER_MIN) : ($past(decay_period) >> 1)));

  p_exp_single_r5: assert property (@(posedge clk) disable iff (rst)
    (|exp_mask) |=> ((exp_mask & $past(exp_mask)) == '0));
endmodule

bind ttl_tag_cache ttl_tag_cache_chk #(
  .NL(SETS * WAYS), .PER_W(PER_W), .PER_MIN(PER_MIN), .PER_MAX(PER_MAX)
) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .fill_valid(fill_valid),
  .rsp_valid(rsp_valid), .fill_done(fill_done), .fill_conflict(fill_conflict),
  .exp_mask(exp_mask), .decay_period(decay_period)
);

// File: tb/tb_ttl_tag_cache.sv
module tb_ttl_tag_cache;
  localparam int CLK_NS = 10;
  localparam int NS = 4, NW = 4, TMIN = 4, PINIT = 16, PMIN = 2, PMAX = 64, PSTEP = 4, NWIN = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic lk_valid = 0, fill_valid = 0;
  logic [1:0] lk_set = 0, fill_set = 0;
  logic [7:0] lk_tag = 0, fill_tag = 0;
  logic rsp_valid, rsp_hit, fill_done, fill_conflict;
  logic [1:0] rsp_way, fill_way;
  logic [15:0] exp_mask;
  logic [7:0] decay_period;

  always #(CLK_NS/2) clk = ~clk;

  ttl_tag_cache dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_set(lk_set), .lk_tag(lk_tag),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
    .fill_valid(fill_valid), .fill_set(fill_set), .fill_tag(fill_tag),
    .fill_done(fill_done), .fill_way(fill_way), .fill_conflict(fill_conflict),
    .exp_mask(exp_mask), .decay_period(decay_period)
  );

  int n_chk = 0, n_bad = 0;
  string phase = "R11 reset";

  bit   m_v[NS][NW];
  int   m_tag[NS][NW];
  int   m_ttl[NS][NW];
  logic [15:0] m_rng;
  int   m_per, m_cnt, m_win;
  bit   e_rv, e_rh, e_fd, e_fc;
  int   e_rw, e_fw, e_per;
  logic [15:0] e_mask;

  function automatic logic [15:0] nxt(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL [%s] phase=%s %s act=%0d exp=%0d", req, phase, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin m_v[s][w] = 0; m_ttl[s][w] = 0; m_tag[s][w] = 0; end
    m_rng = 16'hACE1; m_per = PINIT; m_cnt = 0; m_win = 0;
  endtask

  task automatic model_step(input bit lv, input int ls, input int lt, input bit fv, input int fs, input int ft);
    bit tick, look, hit, conf;
    int hw, vic, rnd, best;
    tick = (m_cnt >= m_per - 1);
    look = lv && !fv;
    hit = 0; hw = 0;
    for (int w = NW - 1; w >= 0; w--)
      if (m_v[ls][w] && m_tag[ls][w] == lt) begin hit = 1; hw = w; end
    conf = 1; vic = 0;
    for (int w = NW - 1; w >= 0; w--)
      if (!m_v[fs][w]) begin conf = 0; vic = w; end
    if (conf) begin
      best = m_ttl[fs][0];
      for (int w = 1; w < NW; w++)
        if (m_ttl[fs][w] < best) begin best = m_ttl[fs][w]; vic = w; end
    end
    rnd = TMIN + int'(m_rng & 16'h7);
    e_mask = '0;
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        if (fv && s == fs && w == vic) begin
          m_v[s][w] = 1; m_tag[s][w] = ft; m_ttl[s][w] = rnd;
        end else if (look && hit && s == ls && w == hw) begin
          m_ttl[s][w] = rnd;
        end else if (tick && m_v[s][w]) begin
          if (m_ttl[s][w] == 1) begin m_v[s][w] = 0; e_mask[s*NW+w] = 1'b1; end
          m_ttl[s][w] = m_ttl[s][w] - 1;
        end
      end
    if (fv || (look && hit)) m_rng = nxt(m_rng);
    if (fv && conf) begin
      m_per = (m_per / 2 < PMIN) ? PMIN : m_per / 2;
      m_win = 0;
    end else if (look) begin
      if (m_win == NWIN - 1) begin
        m_win = 0;
        m_per = (m_per + PSTEP > PMAX) ? PMAX : m_per + PSTEP;
      end else m_win++;
    end
    m_cnt = tick ? 0 : m_cnt + 1;
    e_rv = look; e_rh = look && hit; e_rw = hw;
    e_fd = fv; e_fw = vic; e_fc = fv && conf; e_per = m_per;
  endtask

  task automatic step(input bit lv, input int ls, input int lt, input bit fv, input int fs, input int ft);
    lk_valid = lv; lk_set = 2'(ls); lk_tag = 8'(lt);
    fill_valid = fv; fill_set = 2'(fs); fill_tag = 8'(ft);
    model_step(lv, ls, lt, fv, fs, ft);
    @(posedge clk); #1;
    chk(rsp_valid == e_rv, "R1", "rsp_valid", int'(rsp_valid), int'(e_rv));
    if (e_rv) begin
      chk(rsp_hit == e_rh, "R1", "rsp_hit", int'(rsp_hit), int'(e_rh));
      if (e_rh) chk(int'(rsp_way) == e_rw, "R1", "rsp_way", int'(rsp_way), e_rw);
    end
    chk(fill_done == e_fd, "R7", "fill_done", int'(fill_done), int'(e_fd));
    if (e_fd) begin
      chk(int'(fill_way) == e_fw, "R7", "fill_way", int'(fill_way), e_fw);
      chk(fill_conflict == e_fc, "R7", "fill_conflict", int'(fill_conflict), int'(e_fc));
    end
    chk(exp_mask == e_mask, "R5", "exp_mask", int'(exp_mask), int'(e_mask));
    chk(int'(decay_period) == e_per, "R8/R9", "decay_period", int'(decay_period), e_per);
    lk_valid = 0; fill_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic wait_tick_edge();
    while (m_cnt < m_per - 1) step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_bad++;
    $display("FAIL [watchdog] run did not finish act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1;
    repeat (3) @(posedge clk);
    #1; rst = 0; model_reset();
    // R11 reset values
    chk(rsp_valid == 0, "R11", "rsp_valid", int'(rsp_valid), 0);
    chk(fill_done == 0, "R11", "fill_done", int'(fill_done), 0);
    chk(exp_mask == 0, "R11", "exp_mask", int'(exp_mask), 0);
    chk(int'(decay_period) == PINIT, "R11", "decay_period", int'(decay_period), PINIT);

    phase = "R1 miss on empty";
    step(1, 2, 7, 0, 0, 0);

    phase = "R2 fill lifetime, R4 R5 decay to expiry";
    step(0, 0, 0, 1, 1, 16);
    idle(200);

    phase = "R3 hit refresh";
    step(0, 0, 0, 1, 2, 33);
    for (int k = 0; k < 6; k++) begin idle(20); step(1, 2, 33, 0, 0, 0); end
    idle(150);

    phase = "R6 refresh and fill on tick";
    step(0, 0, 0, 1, 3, 40);
    wait_tick_edge();
    step(1, 3, 40, 0, 0, 0);
    wait_tick_edge();
    step(0, 0, 0, 1, 3, 41);
    idle(10);

    phase = "R7 R8 victim and conflict";
    for (int t = 0; t < 6; t++) step(0, 0, 0, 1, 0, 80 + t);
    idle(3);

    phase = "R9 window growth";
    for (int k = 0; k < 4 * NWIN; k++) step(1, k % NS, 80 + (k % 6), 0, 0, 0);

    phase = "R10 fill and lookup together";
    step(1, 0, 85, 1, 0, 90);
    step(1, 1, 3, 1, 1, 91);
    idle(5);

    phase = "R1 R7 random traffic";
    for (int c = 0; c < 5000; c++) begin
      bit lv, fv;
      lv = ($urandom % 2) == 0;
      fv = ($urandom % 5) == 0;
      if ((c / 500) % 3 == 2) begin lv = 0; fv = 0; end
      step(lv, int'($urandom % NS), int'($urandom % 6), fv, int'($urandom % NS), int'($urandom % 6));
    end
    idle(20);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule